// File: doc/BRIEF.md
# Keyed System Control Register

This block is one 32-bit control word on a chip's register bus. Address decoding has already happened upstream. The block sees a write strobe with write data, and it always presents its read value. A write changes nothing unless the upper half of the write data carries the unlock key. Any write without the key is dropped whole, including every field in its lower half.

The word holds two things:
- a 3-bit interrupt priority grouping field, driven straight out to the interrupt controller;
- a reset request bit, which produces a one-cycle request pulse towards the reset sequencer.

When read, the upper half shows a fixed key constant that differs from the unlock key. The endianness flag reads as little-endian.

The reset request comes from a small state machine with two states:
- `RQ_IDLE`: no request is being driven.
- `RQ_FIRE`: the request output is high.

Its transitions are:
- *arm*, from `RQ_IDLE` to `RQ_FIRE`, on an accepted write with bit 2 set.
- *retrigger*, from `RQ_FIRE` to `RQ_FIRE`, on another such write in the very next cycle.
- *drop*, from `RQ_FIRE` to `RQ_IDLE`, in any other cycle.

Top module: `sysctl_keyreg`

## Requirements
- R1: After reset, `prio_group` is 0, `sys_rst_req` is low, and `rd_data` reads 0xFA050000.
- R2: A write whose bits 31:16 equal 0x05FA is accepted. The new value of bits 10:8 appears on `prio_group` and in `rd_data` one clock after the write edge.
- R3: A write whose bits 31:16 hold any value other than 0x05FA is discarded. `prio_group` and `rd_data` keep their values, and no reset request pulse is produced.
- R4: Bits 31:16 of `rd_data` always read 0xFA05.
- R5: Bit 15 of `rd_data` always reads 0, meaning little-endian, whatever was written to it.
- R6: Bits 10:8 of `rd_data` always equal `prio_group`.
- R7: An accepted write with bit 2 set drives `sys_rst_req` high for exactly the one cycle after the write edge. Bit 2 always reads 0.
- R8: Bits 14:11, 7:3, 1 and 0 always read 0, and writing ones to them has no visible effect.
- R9: Accepted writes with bit 2 set on consecutive cycles keep `sys_rst_req` high for one cycle per write. It falls in the first cycle with no such write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for this register (already decoded) |
| wr_data | input | 32 | Write data, carrying the key in bits 31:16 |
| rd_data | output | 32 | Current read value of the register |
| prio_group | output | 3 | Priority grouping field to the interrupt controller |
| sys_rst_req | output | 1 | One-cycle system reset request pulse |

## Verification
A key comparator that is wrong in any bit either lets a bad key through or refuses the good one. A bad key that gets through changes `prio_group` and the read word one cycle after the write. A refused good key leaves them unchanged in that same cycle. A fault in the request state machine shows up on `sys_rst_req` in the cycle after the write edge: the pulse is missing, stretched, or fires spuriously. The fixed read fields are compared against the full expected word after every write, so a stray stored bit shows at once.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic {
        RQ_IDLE = 1'b0,
        RQ_FIRE = 1'b1
    } rq_state_e;

endpackage

// File: rtl/sysctl_key_gate.sv
module sysctl_key_gate #(
    parameter int          KEY_W  = 16,
    parameter logic [15:0] WR_KEY = 16'h05FA
) (
    input  logic             wr_en,
    input  logic [KEY_W-1:0] key_in,
    output logic             accept
);

    // A write passes only when the strobe is high and the key matches exactly.
    always_comb begin
        accept = wr_en && (key_in == WR_KEY[KEY_W-1:0]);
    end

endmodule

// File: rtl/sysctl_group_reg.sv
module sysctl_group_reg #(
    parameter int GRP_W   = 3,
    parameter int GRP_RST = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             accept,
    input  logic [GRP_W-1:0] grp_in,
    output logic [GRP_W-1:0] grp_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q <= GRP_W'(GRP_RST);
        end else if (accept) begin
            grp_q <= grp_in;
        end
    end

    // R3
    reject_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !accept) |=> $stable(grp_q));

    // R2
    accept_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (grp_q == $past(grp_in)));

endmodule

// File: rtl/sysctl_rstreq_fsm.sv
module sysctl_rstreq_fsm
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_req,
    output logic req_o
);

    rq_state_e state_q;
    rq_state_e state_d;

    // Next-state logic: arm, retrigger and drop transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_IDLE: state_d = fire_req ? RQ_FIRE : RQ_IDLE;
            RQ_FIRE: state_d = fire_req ? RQ_FIRE : RQ_IDLE;
            default: state_d = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode from the state.
    always_comb begin
        unique case (state_q)
            RQ_IDLE: req_o = 1'b0;
            RQ_FIRE: req_o = 1'b1;
            default: req_o = 1'b0;
        endcase
    end

    // R7
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(fire_req));

    // R9
    pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_req |=> req_o);

endmodule

// File: rtl/sysctl_keyreg.sv
module sysctl_keyreg #(
    parameter int          DATA_W     = 32,
    parameter int          KEY_LSB    = 16,
    parameter int          KEY_W      = 16,
    parameter logic [15:0] WR_KEY     = 16'h05FA,
    parameter logic [15:0] RD_KEY     = 16'hFA05,
    parameter int          GRP_LSB    = 8,
    parameter int          GRP_W      = 3,
    parameter int          GRP_RST    = 0,
    parameter int          RSTREQ_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [GRP_W-1:0]  prio_group,
    output logic              sys_rst_req
);

    localparam int KEY_MSB = KEY_LSB + KEY_W - 1;
    localparam int GRP_MSB = GRP_LSB + GRP_W - 1;

    logic accept;
    logic fire_req;
    logic unused_wbits;

    assign unused_wbits = ^wr_data;

    sysctl_key_gate #(
        .KEY_W  (KEY_W),
        .WR_KEY (WR_KEY)
    ) u_gate (
        .wr_en  (wr_en),
        .key_in (wr_data[KEY_MSB:KEY_LSB]),
        .accept (accept)
    );

    sysctl_group_reg #(
        .GRP_W   (GRP_W),
        .GRP_RST (GRP_RST)
    ) u_group (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .accept (accept),
        .grp_in (wr_data[GRP_MSB:GRP_LSB]),
        .grp_q  (prio_group)
    );

    assign fire_req = accept && wr_data[RSTREQ_BIT];

    sysctl_rstreq_fsm u_rq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_req (fire_req),
        .req_o    (sys_rst_req)
    );

    // Read word: key constant on top, group field in place, everything else 0.
    always_comb begin
        rd_data = '0;
        rd_data[KEY_MSB:KEY_LSB] = RD_KEY[KEY_W-1:0];
        rd_data[GRP_MSB:GRP_LSB] = prio_group;
    end

    // R3
    bad_key_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[KEY_MSB:KEY_LSB] != WR_KEY[KEY_W-1:0]
            && !sys_rst_req) |=> !sys_rst_req);

    // R6
    group_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prio_group) == $past(rd_data[GRP_MSB:GRP_LSB]));

endmodule

// File: tb/tb_sysctl_keyreg.sv
module tb_sysctl_keyreg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  prio_group;
    logic        sys_rst_req;

    int checks = 0;
    int errors = 0;
    logic [2:0] exp_grp = 3'd0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sysctl_keyreg dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .prio_group (prio_group),
        .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [2:0] g);
        return {16'hFA05, 5'b0, g, 8'h00};
    endfunction

    // Drive one write for one cycle; returns at the following falling edge.
    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 group", {29'd0, prio_group}, 32'd0);
        chk("R1 req", {31'd0, sys_rst_req}, 32'd0);
        chk("R1 read", rd_data, 32'hFA05_0000);
        rst_n = 1'b1;

        // R2 R6: sweep every group value with the good key
        for (int g = 0; g < 8; g++) begin
            wr({16'h05FA, 5'b0, 3'(g), 8'h00});
            exp_grp = 3'(g);
            chk("R2 group", {29'd0, prio_group}, {29'd0, exp_grp});
            chk("R6 read", rd_data, exp_word(exp_grp));
            chk("R3 no pulse on plain write", {31'd0, sys_rst_req}, 32'd0);
        end

        // R3: every single-bit corruption of the key, plus sample keys
        for (int b = 0; b < 16; b++) begin
            logic [15:0] k;
            k = 16'h05FA ^ (16'h1 << b);
            wr({k, 16'h0204 ^ {5'b0, exp_grp, 8'h00}});
            chk("R3 bad key group", {29'd0, prio_group}, {29'd0, exp_grp});
            chk("R3 bad key read", rd_data, exp_word(exp_grp));
            chk("R3 bad key pulse", {31'd0, sys_rst_req}, 32'd0);
        end
        wr(32'hFA05_0704);
        chk("R3 read key rejected", rd_data, exp_word(exp_grp));
        chk("R3 read key no pulse", {31'd0, sys_rst_req}, 32'd0);
        wr(32'h0000_0304);
        chk("R3 zero key rejected", rd_data, exp_word(exp_grp));

        // R4 R5 R8: ones in every unused bit with the good key
        wr({16'h05FA, 16'hF8FB});
        exp_grp = 3'd0;
        chk("R8 R5 R4 reserved bits read 0", rd_data, exp_word(exp_grp));
        chk("R7 bit2 reads 0", {31'd0, rd_data[2]}, 32'd0);
        chk("R5 endian bit", {31'd0, rd_data[15]}, 32'd0);
        chk("R4 key field", {16'd0, rd_data[31:16]}, 32'h0000_FA05);

        // R7: single pulse
        wr({16'h05FA, 16'h0504});
        exp_grp = 3'd5;
        chk("R7 pulse high", {31'd0, sys_rst_req}, 32'd1);
        chk("R7 group with pulse", {29'd0, prio_group}, 32'd5);
        chk("R7 bit2 reads 0", rd_data, exp_word(exp_grp));
        @(negedge clk);
        chk("R7 pulse one cycle", {31'd0, sys_rst_req}, 32'd0);

        // R9: three back-to-back requesting writes
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 32'h05FA_0104;
        @(negedge clk);
        chk("R9 first", {31'd0, sys_rst_req}, 32'd1);
        wr_data = 32'h05FA_0204;
        @(negedge clk);
        chk("R9 second", {31'd0, sys_rst_req}, 32'd1);
        wr_data = 32'h05FA_0304;
        @(negedge clk);
        chk("R9 third", {31'd0, sys_rst_req}, 32'd1);
        wr_en = 1'b0;
        wr_data = '0;
        @(negedge clk);
        chk("R9 falls", {31'd0, sys_rst_req}, 32'd0);
        chk("R9 last group", {29'd0, prio_group}, 32'd3);

        // R1: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 group after reset", {29'd0, prio_group}, 32'd0);
        chk("R1 read after reset", rd_data, 32'hFA05_0000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule